// File: doc/BRIEF.md
# Packed SIMD Adder with Element Offset

This block adds packed lanes held in 32-bit words, either four 8-bit lanes or two 16-bit lanes. The second operand feeds its lanes straight across. The first operand is read as a window over two adjacent words (a low word and the word after it), starting a programmable number of elements into the low word. With a non-zero offset, the upper lanes of the window spill over into the low lanes of the following word. The effect is the same as an unaligned element access, but it is done with an element-granular byte shuffle in front of the adders.

The caller presents both first-operand words, the addend word, the lane-width select, the element offset and a flag for non-packed operation, all together with a valid strobe. One clock later the result word appears with its own valid strobe. In non-packed operation the offset input is ignored and treated as zero.

Top module: `packed_offset_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `sum_word` are cleared to zero at that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and `sum_word` then holds the result of that cycle's inputs.
- R3: With `wide_mode`=0 (8-bit lanes, lane i = bits 8i+7..8i) and an effective offset of zero, result lane i is the sum of `lo_word` lane i and `addend` lane i.
- R4: With `wide_mode`=0 and offset k (0..3), result lane i is the sum of byte i+k of the 64-bit window {`hi_word`,`lo_word`} and `addend` lane i. Window bytes 0..3 are `lo_word` bytes 0..3, and window bytes 4..7 are `hi_word` bytes 0..3.
- R5: With `wide_mode`=1 (16-bit lanes, lane i = bits 16i+15..16i) and offset k, result lane i is the sum of window 16-bit unit i+k and `addend` lane i.
- R6: Every lane sum wraps modulo 2^lane-width. No carry passes from one lane into the next. In 16-bit mode the carry does pass between the two bytes of a lane.
- R7: When `unpacked`=1, `lane_shift` has no effect, and the result equals the offset-zero result for the selected width.
- R8: In 16-bit mode only bit 0 of `lane_shift` is used, so offsets 2 and 3 give the same result as offsets 0 and 1.
- R9: While `in_valid` is low, `sum_word` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs of this cycle are to be added |
| lo_word | input | 32 | First-operand word where the window starts |
| hi_word | input | 32 | First-operand word that follows lo_word |
| addend | input | 32 | Second operand, never shifted |
| wide_mode | input | 1 | 0 = four 8-bit lanes, 1 = two 16-bit lanes |
| unpacked | input | 1 | 1 = non-packed operation, offset forced to zero |
| lane_shift | input | 2 | Element offset into the window |
| out_valid | output | 1 | sum_word holds a fresh result |
| sum_word | output | 32 | Registered lane-wise sum |

## Verification
Every combination of width, offset and the non-packed flag is driven with all-ones, all-zero, carry-provoking and random operands. Each result is compared against a model that shifts the 64-bit concatenation of the two words.

Each test targets a specific failure:
- All-ones lanes plus one expose any carry that leaks between lanes, and any 16-bit lane that fails to carry between its two bytes.
- Offsets 3 and 1 catch a window that wraps back into the low word instead of spilling into the next word.
- Offsets 2 and 3 in 16-bit mode catch use of the upper offset bit.
- Non-packed operation with a non-zero offset catches a shift that was not suppressed.
- Idle gaps catch a result register that does not hold its value, or a valid strobe that is not a single-cycle echo of its input.

// File: rtl/spa_pkg.sv
// Package: shared constants and types for the packed offset adder.
// Assumes a word is a whole number of 8-bit bytes.
package spa_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    // Lane width selector as seen on the wide_mode pin.
    typedef enum logic {
        ELEM_8  = 1'b0,
        ELEM_16 = 1'b1
    } elem_w_e;
endpackage

// File: rtl/spa_offset_resolver.sv
// Module: turns the element offset into a byte shift for the window.
// Assumes 16-bit elements are two bytes; only the low offset bit is used
// for them, and non-packed operation forces the shift to zero.
module spa_offset_resolver
    import spa_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int SHIFT_W  = $clog2(NUM_BYTES)
) (
    input  elem_w_e            width_sel,
    input  logic               unpacked,
    input  logic [SHIFT_W-1:0] lane_shift,
    output logic [SHIFT_W-1:0] byte_shift
);
    // Purpose: pick the byte distance from width and offset.
    always_comb begin
        if (unpacked) begin
            byte_shift = '0;
        end else if (width_sel == ELEM_16) begin
            byte_shift = {lane_shift[0], 1'b0};
        end else begin
            byte_shift = lane_shift;
        end
    end
endmodule

// File: rtl/spa_window_shifter.sv
// Module: byte funnel shifter over two adjacent words.
// Output byte b is byte b+shift of {hi,lo}; assumes shift < NUM_BYTES.
module spa_window_shifter
    import spa_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int SHIFT_W  = $clog2(NUM_BYTES),
    localparam int W        = NUM_BYTES * BYTE_W
) (
    input  logic [W-1:0]       lo_word,
    input  logic [W-1:0]       hi_word,
    input  logic [SHIFT_W-1:0] byte_shift,
    output logic [W-1:0]       window
);
    logic [BYTE_W-1:0] cat_bytes [2*NUM_BYTES];

    // Purpose: split the concatenated pair into bytes, low word first.
    always_comb begin
        for (int j = 0; j < NUM_BYTES; j++) begin
            cat_bytes[j]             = lo_word[j*BYTE_W +: BYTE_W];
            cat_bytes[j + NUM_BYTES] = hi_word[j*BYTE_W +: BYTE_W];
        end
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        logic [SHIFT_W:0] src_idx;
        // Purpose: choose the source byte for output byte b.
        always_comb begin
            src_idx = (SHIFT_W+1)'(b) + {1'b0, byte_shift};
            window[b*BYTE_W +: BYTE_W] = cat_bytes[src_idx];
        end
    end
endmodule

// File: rtl/spa_lane_adder.sv
// Module: byte-sliced adder whose carries link bytes only inside a lane.
// Assumes lanes of one or two bytes; carry into the odd byte of each
// pair is enabled in 16-bit mode only.
module spa_lane_adder
    import spa_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int W        = NUM_BYTES * BYTE_W
) (
    input  elem_w_e      width_sel,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    logic [NUM_BYTES-1:0] carry_out;
    logic [NUM_BYTES-1:0] carry_in;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slice
        logic [BYTE_W:0] part;
        if (b % 2 == 1) begin : g_link
            // Purpose: pass the low byte's carry within a 16-bit lane.
            always_comb carry_in[b] = (width_sel == ELEM_16) & carry_out[b-1];
        end else begin : g_break
            // Purpose: even bytes start a lane and take no carry.
            always_comb carry_in[b] = 1'b0;
        end
        // Purpose: add one byte slice and expose its carry.
        always_comb begin
            part = {1'b0, op_a[b*BYTE_W +: BYTE_W]}
                 + {1'b0, op_b[b*BYTE_W +: BYTE_W]}
                 + {{BYTE_W{1'b0}}, carry_in[b]};
            sum[b*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
            carry_out[b] = part[BYTE_W];
        end
    end
endmodule

// File: rtl/packed_offset_adder.sv
// Module: top of the packed adder with element offset on operand A.
// Resolves the offset, shifts the two-word window, adds lane-wise and
// registers the result with one cycle of latency. Synchronous active-low reset.
module packed_offset_adder
    import spa_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    localparam int NUM_BYTES = DATA_W / BYTE_W,
    localparam int SHIFT_W   = $clog2(NUM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  lo_word,
    input  logic [DATA_W-1:0]  hi_word,
    input  logic [DATA_W-1:0]  addend,
    input  logic               wide_mode,
    input  logic               unpacked,
    input  logic [SHIFT_W-1:0] lane_shift,
    output logic               out_valid,
    output logic [DATA_W-1:0]  sum_word
);
    elem_w_e            width_sel;
    logic [SHIFT_W-1:0] byte_shift;
    logic [DATA_W-1:0]  window;
    logic [DATA_W-1:0]  lane_sum;

    // Purpose: map the width pin onto the shared enum.
    always_comb width_sel = elem_w_e'(wide_mode);

    spa_offset_resolver #(.NUM_BYTES(NUM_BYTES)) u_resolve (
        .width_sel  (width_sel),
        .unpacked   (unpacked),
        .lane_shift (lane_shift),
        .byte_shift (byte_shift)
    );

    spa_window_shifter #(.NUM_BYTES(NUM_BYTES)) u_shift (
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .byte_shift (byte_shift),
        .window     (window)
    );

    spa_lane_adder #(.NUM_BYTES(NUM_BYTES)) u_add (
        .width_sel (width_sel),
        .op_a      (window),
        .op_b      (addend),
        .sum       (lane_sum)
    );

    // Purpose: register the result and echo the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_word <= lane_sum;
            end
        end
    end
endmodule

// File: rtl/spa_checker.sv
// Module: protocol and datapath assertions for packed_offset_adder,
// bound to every instance of the top.
module spa_checker #(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               wide_mode,
    input logic               unpacked,
    input logic [DATA_W-1:0]  lo_word,
    input logic [SHIFT_W-1:0] byte_shift,
    input logic [DATA_W-1:0]  window,
    input logic               out_valid,
    input logic [DATA_W-1:0]  sum_word
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum_word == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_word)); // R9
    AST_ZERO_SHIFT_PASSES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_shift == '0) |-> (window == lo_word)); // R3
    AST_UNPACKED_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        unpacked |-> (byte_shift == '0)); // R7
    AST_WIDE_EVEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        wide_mode |-> !byte_shift[0]); // R5
endmodule

bind packed_offset_adder spa_checker #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .wide_mode  (wide_mode),
    .unpacked   (unpacked),
    .lo_word    (lo_word),
    .byte_shift (byte_shift),
    .window     (window),
    .out_valid  (out_valid),
    .sum_word   (sum_word)
);

// File: tb/sim_packed_offset_adder.sv
`timescale 1ns/1ps
// Bench: behavioural reference over the 64-bit concatenation, compared
// at every falling edge against the registered outputs.
module sim_packed_offset_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] lo_word = '0;
    logic [31:0] hi_word = '0;
    logic [31:0] addend = '0;
    logic        wide_mode = 1'b0;
    logic        unpacked = 1'b0;
    logic [1:0]  lane_shift = '0;
    logic        out_valid;
    logic [31:0] sum_word;

    int checks = 0;
    int errors = 0;
    logic        exp_valid = 1'b0;
    logic [31:0] exp_sum = '0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    packed_offset_adder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .lo_word(lo_word), .hi_word(hi_word), .addend(addend),
        .wide_mode(wide_mode), .unpacked(unpacked), .lane_shift(lane_shift),
        .out_valid(out_valid), .sum_word(sum_word)
    );

    // Reference: shift the concatenated pair by whole elements, add lanes.
    function automatic logic [31:0] ref_sum(input logic [31:0] lo, input logic [31:0] hi,
                                            input logic [31:0] b, input logic wide,
                                            input logic unp, input logic [1:0] k);
        logic [63:0] pair;
        logic [31:0] r;
        int esz, lanes, off;
        esz   = wide ? 16 : 8;
        lanes = 32 / esz;
        off   = unp ? 0 : (wide ? int'(k[0]) : int'(k));
        pair  = {hi, lo} >> (off * esz);
        r = '0;
        for (int i = 0; i < lanes; i++) begin
            if (wide) r[i*16 +: 16] = pair[i*16 +: 16] + b[i*16 +: 16];
            else      r[i*8 +: 8]   = pair[i*8 +: 8]   + b[i*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check the previous cycle's result, then drive new inputs.
    task automatic step(input string tag, input logic v, input logic [31:0] lo,
                        input logic [31:0] hi, input logic [31:0] b,
                        input logic wide, input logic unp, input logic [1:0] k);
        logic [32:0] e;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            exp_valid = e[32];
            if (e[32]) exp_sum = e[31:0];
            check({t, " valid"}, {31'b0, out_valid}, {31'b0, exp_valid});
            check({t, " sum"}, sum_word, exp_sum);
        end
        in_valid = v; lo_word = lo; hi_word = hi; addend = b;
        wide_mode = wide; unpacked = unp; lane_shift = k;
        exp_q.push_back({v, ref_sum(lo, hi, b, wide, unp, k)});
        tag_q.push_back(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 sum", sum_word, 32'd0);
        rst_n = 1'b1;

        // R3: aligned 8-bit adds
        step("R3", 1, 32'h04030201, 32'hFFFFFFFF, 32'h10203040, 0, 0, 0);
        step("R3", 1, 32'h00000000, 32'h12345678, 32'h00000000, 0, 0, 0);
        // R4: every 8-bit offset, spill into hi_word
        for (int k = 0; k < 4; k++) begin
            step("R4", 1, 32'h44332211, 32'h88776655, 32'h01010101, 0, 0, 2'(k));
            step("R4", 1, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 0, 0, 2'(k));
        end
        // R5: 16-bit offsets 0 and 1
        step("R5", 1, 32'h22221111, 32'h44443333, 32'h00010002, 1, 0, 0);
        step("R5", 1, 32'h22221111, 32'h44443333, 32'h00010002, 1, 0, 1);
        // R6: wrap without inter-lane carry; intra-lane carry in 16-bit
        step("R6", 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h01010101, 0, 0, 0);
        step("R6", 1, 32'h00FF00FF, 32'h0, 32'h00010001, 1, 0, 0);
        step("R6", 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00010001, 1, 0, 1);
        // R7: non-packed ignores the offset
        for (int k = 1; k < 4; k++) begin
            step("R7", 1, 32'h44332211, 32'h88776655, 32'h0, 0, 1, 2'(k));
            step("R7", 1, 32'h44332211, 32'h88776655, 32'h0, 1, 1, 2'(k));
        end
        // R8: upper offset bit unused for 16-bit lanes
        step("R8", 1, 32'hBBBBAAAA, 32'hDDDDCCCC, 32'h0, 1, 0, 2);
        step("R8", 1, 32'hBBBBAAAA, 32'hDDDDCCCC, 32'h0, 1, 0, 3);
        // R9 and R2: idle gaps hold the result, valid echoes input
        step("R9", 0, 32'h12345678, 32'h9ABCDEF0, 32'h11111111, 0, 0, 1);
        step("R9", 0, 32'h0, 32'h0, 32'h0, 1, 0, 0);
        step("R2", 1, 32'hCAFEF00D, 32'h0BADBEEF, 32'h01020304, 0, 0, 3);
        step("R2", 0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        // R4/R5 random sweep over all combinations
        for (int n = 0; n < 400; n++) begin
            logic w;
            w = 1'($urandom);
            step(w ? "R5" : "R4", 1'($urandom_range(0, 3) != 0), $urandom, $urandom,
                 $urandom, w, 1'($urandom_range(0, 7) == 0), 2'($urandom));
        end
        step("R2", 0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        step("R2", 0, 32'h0, 32'h0, 32'h0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule